// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This unit is the arithmetic core of a fixed-point signal-processing data path. A 16x16 multiplier produces either a fractional signed product (aligned by a one-bit left shift) or a signed-by-unsigned product for building wider multiplications. The product is written to, or accumulated into, one of a bank of 36-bit accumulators. Each accumulator holds 32 bits of product range and 4 guard bits above them. The same unit also clears an accumulator, takes its absolute value, adds an accumulator to another, and adds a 32-bit operand with an incoming carry.

An operation is presented by placing an opcode, two 16-bit operands, a destination accumulator select, a source accumulator select and a carry input on the ports, and raising the valid strobe for one clock. The result is written into the selected accumulator at that clock edge. At the same edge a five-bit condition-code word is updated (extension, negative, zero, overflow, carry). One operation loads zero without touching the condition codes. This lets a register be reset without disturbing flags that later code still needs.

Top module: `fmac_unit`

## Requirements
- R1: Opcode 0 (multiply) writes the signed 16x16 product shifted left by one, sign-extended to 36 bits, into accumulator `dst_i`. When `neg_i` is 1 the product is negated first. `neg_i` also applies to opcodes 1 and 2.
- R2: For opcodes 0, 1 and 2, the operand pair 0x8000 x 0x8000 gives the product 0x0_7FFF_FFFF (before any negation) and sets the overflow flag.
- R3: Opcode 1 (multiply-accumulate) adds the opcode-0 product to the destination accumulator over 36 bits. C is the carry out of bit 35. V is the signed overflow of the sum, ORed with the R2 saturation.
- R4: Opcode 2 (rounded multiply) adds 0x8000 to the 36-bit opcode-0 product, clears bits 15:0 and writes the result. V follows R2.
- R5: Opcode 3 (mixed multiply) treats `src_a_i` as two's complement and `src_b_i` as unsigned. It writes the unshifted 32-bit product, sign-extended from bit 31 to 36 bits, and sets V to 0.
- R6: Opcode 4 (mixed multiply-accumulate) adds the R5 product to the destination accumulator. C and V come from the 36-bit addition.
- R7: Opcode 5 (clear) zeroes the destination and sets the flags to exactly Z=1, with all other flags 0.
- R8: Opcode 6 (load zero) zeroes the destination and leaves all five flags unchanged.
- R9: Opcode 7 (absolute value) replaces the destination with its magnitude. The most negative 36-bit value 0x8_0000_0000 stays unchanged and sets V.
- R10: Opcode 8 (add with carry) adds the 32-bit value {src_a_i, src_b_i}, sign-extended to 36 bits, plus `carry_i` to the destination. C is the carry out of bit 35.
- R11: Opcode 9 (accumulator add) adds accumulator `acc_src_i` to the destination over 36 bits. C and V come from the sum.
- R12: `flags_o` bits are {E,N,Z,V,C} from bit 4 down to bit 0. N is result bit 35. Z is set when all 36 result bits are 0. E is set when bits 35..31 are not all equal. C is 0 for opcodes 0, 2, 3 and 7. V is 0 for opcodes 3 and 5.
- R13: With `valid_i` low, no accumulator and no flag changes. A valid operation changes only the selected destination. Accumulator k is at `acc_o[36k+35:36k]`.
- R14: After reset, all accumulators and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Execute the presented operation on this edge |
| op_i | input | 4 | Operation code (0..9) |
| neg_i | input | 1 | Negate the signed product (opcodes 0..2) |
| src_a_i | input | 16 | First operand (always signed) |
| src_b_i | input | 16 | Second operand (unsigned in opcodes 3, 4) |
| dst_i | input | 1 | Destination accumulator select |
| acc_src_i | input | 1 | Source accumulator for opcode 9 |
| carry_i | input | 1 | Carry input for opcode 8 |
| acc_o | output | 72 | All accumulators, accumulator k at bits 36k+35:36k |
| flags_o | output | 5 | Condition codes {E,N,Z,V,C} |

## Verification
Two functions can fall in the same cycle. In the multiply-accumulate path, product saturation and the accumulator adder's own signed overflow and carry are produced together, and both feed V. In the rounded path, the negation and the rounding addition act on one product. The bench provokes both cases by sweeping every pair from a set of edge operands (0x8000, 0x7FFF, 0xFFFF, 0x8001 among them) through every multiply opcode with and without negation, while the accumulator keeps running towards its guard bits. After each operation it compares every accumulator and the flag word with an arithmetic model built from the requirements.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    typedef enum logic [3:0] {
        OP_MPY   = 4'd0,
        OP_MAC   = 4'd1,
        OP_MPYR  = 4'd2,
        OP_MPYSU = 4'd3,
        OP_MACSU = 4'd4,
        OP_CLR   = 4'd5,
        OP_ZERO  = 4'd6,
        OP_ABS   = 4'd7,
        OP_ADC   = 4'd8,
        OP_ADD   = 4'd9
    } fmac_op_e;

    typedef struct packed {
        logic ext;
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } fmac_flags_t;

endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
    parameter int DW = 16,
    parameter int AW = 36
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          neg_i,
    input  logic          mixed_i,
    output logic [AW-1:0] prod_o,
    output logic          sat_o
);
    localparam int PW = 2 * DW;
    localparam int GW = AW - PW;
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW-1:0] a_x, b_sx, b_ux;
    logic signed [PW-1:0] p_ss, p_su, frac;
    logic        [PW-1:0] pick;
    logic        [AW-1:0] wide;

    always_comb begin
        a_x   = {{DW{a_i[DW-1]}}, a_i};
        b_sx  = {{DW{b_i[DW-1]}}, b_i};
        b_ux  = {{DW{1'b0}}, b_i};
        p_ss  = a_x * b_sx;
        p_su  = a_x * b_ux;
        sat_o = !mixed_i && (a_i == MINV) && (b_i == MINV);
        frac  = sat_o ? {1'b0, {(PW-1){1'b1}}} : (p_ss <<< 1);
        pick  = mixed_i ? p_su : frac;
        wide  = {{GW{pick[PW-1]}}, pick};
        prod_o = (neg_i && !mixed_i) ? (~wide + 1'b1) : wide;
    end

endmodule

// File: rtl/fmac_add.sv
module fmac_add #(
    parameter int AW = 36
) (
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    input  logic          cin_i,
    output logic [AW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    logic [AW:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{AW{1'b0}}, cin_i};
        sum_o  = full[AW-1:0];
        cout_o = full[AW];
        ovf_o  = (a_i[AW-1] == b_i[AW-1]) && (full[AW-1] != a_i[AW-1]);
    end

endmodule

// File: rtl/fmac_flags.sv
module fmac_flags
    import fmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 36
) (
    input  logic [AW-1:0] res_i,
    input  logic          cry_i,
    input  logic          ovf_i,
    output fmac_flags_t   flg_o
);
    localparam int TOPL = 2 * DW - 1;

    logic [AW-1-TOPL:0] top;

    always_comb begin
        top        = res_i[AW-1:TOPL];
        flg_o.ext  = !((&top) || !(|top));
        flg_o.neg  = res_i[AW-1];
        flg_o.zero = (res_i == '0);
        flg_o.ovf  = ovf_i;
        flg_o.cry  = cry_i;
    end

endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
    import fmac_pkg::*;
#(
    parameter  int DW   = 16,
    parameter  int GW   = 4,
    parameter  int NACC = 2,
    localparam int AW   = 2 * DW + GW,
    localparam int SELW = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               valid_i,
    input  logic [3:0]         op_i,
    input  logic               neg_i,
    input  logic [DW-1:0]      src_a_i,
    input  logic [DW-1:0]      src_b_i,
    input  logic [SELW-1:0]    dst_i,
    input  logic [SELW-1:0]    acc_src_i,
    input  logic               carry_i,
    output logic [NACC*AW-1:0] acc_o,
    output logic [4:0]         flags_o
);
    localparam logic [AW-1:0] RND = AW'(1) << (DW - 1);

    typedef struct packed {
        logic [NACC-1:0][AW-1:0] acc;
        fmac_flags_t             flg;
    } state_t;

    state_t      state_d, state_q;
    fmac_op_e    op;
    logic        mixed, sat;
    logic [AW-1:0] prod, cur, oth;
    logic [AW-1:0] add_a, add_b, sum;
    logic        add_c, cout, ovf;
    logic [AW-1:0] res;
    logic        res_c, res_v, wr;
    fmac_flags_t nflg;

    assign op    = fmac_op_e'(op_i);
    assign mixed = (op == OP_MPYSU) || (op == OP_MACSU);
    assign cur   = state_q.acc[dst_i];
    assign oth   = state_q.acc[acc_src_i];

    fmac_mult #(.DW(DW), .AW(AW)) u_mult (
        .a_i(src_a_i), .b_i(src_b_i), .neg_i(neg_i), .mixed_i(mixed),
        .prod_o(prod), .sat_o(sat)
    );

    always_comb begin
        add_a = cur;
        add_b = prod;
        add_c = 1'b0;
        unique case (op)
            OP_ADC:  begin
                add_b = {{(GW + DW){src_a_i[DW-1]}}, src_a_i, src_b_i} >> 0;
                add_b = {{GW{src_a_i[DW-1]}}, src_a_i, src_b_i};
                add_c = carry_i;
            end
            OP_ADD:  add_b = oth;
            OP_MPYR: begin
                add_a = prod;
                add_b = RND;
            end
            default: ;
        endcase
    end

    fmac_add #(.AW(AW)) u_add (
        .a_i(add_a), .b_i(add_b), .cin_i(add_c),
        .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
    );

    always_comb begin
        res   = '0;
        res_c = 1'b0;
        res_v = 1'b0;
        wr    = 1'b1;
        unique case (op)
            OP_MPY:   begin res = prod; res_v = sat; end
            OP_MAC:   begin res = sum; res_c = cout; res_v = ovf | sat; end
            OP_MPYR:  begin res = {sum[AW-1:DW], {DW{1'b0}}}; res_v = sat; end
            OP_MPYSU: res = prod;
            OP_MACSU: begin res = sum; res_c = cout; res_v = ovf; end
            OP_CLR:   res = '0;
            OP_ZERO:  res = '0;
            OP_ABS:   begin
                res   = cur[AW-1] ? (~cur + 1'b1) : cur;
                res_v = cur[AW-1] && res[AW-1];
            end
            OP_ADC, OP_ADD: begin res = sum; res_c = cout; res_v = ovf; end
            default:  wr = 1'b0;
        endcase
    end

    fmac_flags #(.DW(DW), .AW(AW)) u_flags (
        .res_i(res), .cry_i(res_c), .ovf_i(res_v), .flg_o(nflg)
    );

    always_comb begin
        state_d = state_q;
        if (valid_i && wr) begin
            state_d.acc[dst_i] = res;
            if (op != OP_ZERO) begin
                state_d.flg = nflg;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar k = 0; k < NACC; k++) begin : g_out
        assign acc_o[k*AW +: AW] = state_q.acc[k];

        AST_OTHER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!valid_i || (dst_i != SELW'(k))) |=> $stable(acc_o[k*AW +: AW])); // R13
    end

    assign flags_o = state_q.flg;

    AST_IDLE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(flags_o)); // R13

    AST_ZERO_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd6) |=> $stable(flags_o)); // R8

    AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd5) |=> (flags_o == 5'b00100)); // R7

    AST_RND_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd2) |=> (acc_o[$past(dst_i)*AW +: DW] == '0)); // R4

    AST_SAT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd0 && !neg_i && src_a_i == 16'h8000 && src_b_i == 16'h8000)
        |=> (acc_o[$past(dst_i)*AW +: AW] == {{(GW+1){1'b0}}, {(2*DW-1){1'b1}}}) && flags_o[1]); // R2

    AST_MIXED_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd3) |=> !flags_o[1] && !flags_o[0]); // R5

endmodule

// File: tb/tb_fmac_unit.sv
module tb_fmac_unit;
    localparam int CLK_PERIOD = 10;
    localparam longint M36 = 64'hF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  op = '0;
    logic        neg = 1'b0;
    logic [15:0] sa = '0, sb = '0;
    logic        dst = 1'b0, asrc = 1'b0, cin = 1'b0;
    logic [71:0] acc;
    logic [4:0]  flags;

    int checks = 0;
    int errors = 0;

    longint macc [2];
    logic [4:0] mflg;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmac_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .neg_i(neg),
        .src_a_i(sa), .src_b_i(sb), .dst_i(dst), .acc_src_i(asrc),
        .carry_i(cin), .acc_o(acc), .flags_o(flags)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic add36(input longint u, input longint w, input bit ci,
                         output longint r, output bit c, output bit v);
        longint s;
        s = u + w + longint'(ci);
        c = s[36];
        r = s & M36;
        v = (u[35] == w[35]) && (r[35] != u[35]);
    endtask

    task automatic model(input int o, input logic [15:0] a, input logic [15:0] b,
                         input bit ng, input int d, input int s, input bit ci);
        longint p, x, r;
        bit c, v, sat;
        c = 0; v = 0; sat = 0; p = 0; r = 0;
        x = macc[d];
        if (o <= 2) begin
            p = longint'($signed(a)) * longint'($signed(b));
            if (a == 16'h8000 && b == 16'h8000) begin p = 64'h7FFF_FFFF; sat = 1; end
            else p = p * 2;
            if (ng) p = -p;
        end else if (o <= 4) begin
            p = longint'($signed(a)) * longint'(b);
        end
        case (o)
            0, 3: begin r = p & M36; v = sat; end
            1, 4: begin add36(x, p & M36, 0, r, c, v); v = v | sat; end
            2: begin r = ((p + 64'h8000) & M36) & ~64'hFFFF; v = sat; end
            5, 6: r = 0;
            7: begin
                if (x[35]) begin r = (-x) & M36; v = (x == 64'h8_0000_0000); end
                else r = x;
            end
            8: add36(x, longint'($signed({a, b})) & M36, ci, r, c, v);
            9: add36(x, macc[s], 0, r, c, v);
            default: r = x;
        endcase
        macc[d] = r;
        if (o == 5) mflg = 5'b00100;
        else if (o != 6)
            mflg = {!(r[35:31] == 5'h1F || r[35:31] == 5'h00), r[35], (r == 0), v, c};
    endtask

    function automatic string tag_of(input int o, input logic [15:0] a, input logic [15:0] b);
        case (o)
            0: tag_of = (a == 16'h8000 && b == 16'h8000) ? "R2" : "R1";
            1: tag_of = "R3";
            2: tag_of = "R4";
            3: tag_of = "R5";
            4: tag_of = "R6";
            5: tag_of = "R7";
            6: tag_of = "R8";
            7: tag_of = "R9";
            8: tag_of = "R10";
            default: tag_of = "R11";
        endcase
    endfunction

    task automatic compare_all(input string tag);
        chk({tag, " acc0"}, longint'(acc[35:0]), macc[0]);
        chk({tag, " acc1 R13"}, longint'(acc[71:36]), macc[1]);
        chk({tag, " flags R12"}, longint'(flags), longint'(mflg));
    endtask

    task automatic do_op(input int o, input logic [15:0] a, input logic [15:0] b,
                         input bit ng, input int d, input int s, input bit ci);
        @(negedge clk);
        valid = 1'b1; op = 4'(o); sa = a; sb = b; neg = ng;
        dst = d[0]; asrc = s[0]; cin = ci;
        @(negedge clk);
        valid = 1'b0;
        model(o, a, b, ng, d, s, ci);
        compare_all(tag_of(o, a, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] vals [9];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                 16'h4000, 16'hC000, 16'h1234, 16'h8001};
        macc[0] = 0; macc[1] = 0; mflg = '0;

        repeat (3) @(negedge clk);
        // R14: reset state
        chk("R14 acc", longint'(acc[35:0]) | longint'(acc[71:36]), 0);
        chk("R14 flags", longint'(flags), 0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            for (int j = 0; j < 9; j++) begin
                int d;
                d = (i + j) % 2;
                for (int ng = 0; ng < 2; ng++) begin
                    do_op(0, vals[i], vals[j], ng[0], d, 0, 0);
                    do_op(2, vals[i], vals[j], ng[0], 1 - d, 0, 0);
                    do_op(1, vals[i], vals[j], ng[0], d, 0, 0);
                end
                do_op(3, vals[i], vals[j], 0, d, 0, 0);
                do_op(4, vals[i], vals[j], 0, 1 - d, 0, 0);
                do_op(8, vals[i], vals[j], 0, d, 0, j[0]);
                do_op(9, 0, 0, 0, d, 1 - d, 0);
                do_op(7, 0, 0, 0, 1 - d, 0, 0);
            end
        end

        // R9: most negative value through ABS
        do_op(5, 0, 0, 0, 0, 0, 0);
        do_op(8, 16'h8000, 16'h0000, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) do_op(9, 0, 0, 0, 0, 0, 0);
        chk("R9 setup", longint'(acc[35:0]), 64'h8_0000_0000);
        do_op(7, 0, 0, 0, 0, 0, 0);

        // R11: overflowing 36-bit add, then R8 zero load keeps flags
        do_op(9, 0, 0, 0, 0, 0, 0);
        do_op(8, 16'hFFFF, 16'hFFFF, 0, 1, 0, 1);
        do_op(6, 0, 0, 0, 1, 0, 0);
        do_op(7, 0, 0, 0, 0, 0, 0);
        do_op(1, 16'h8000, 16'h8001, 1, 0, 0, 0);
        do_op(6, 0, 0, 0, 0, 0, 0);
        do_op(5, 0, 0, 0, 1, 0, 0);

        // R13: strobe low, other inputs toggling
        do_op(0, 16'h7FFF, 16'h7FFF, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            op = 4'(k); sa = 16'h8000; sb = 16'h8000; dst = k[0];
            @(negedge clk);
            compare_all("R13 idle");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule